// File: doc/BRIEF.md
# Keyed-Service Watchdog Timer

This peripheral guards a system against software that has stopped making progress. A 16-bit down-counter runs while the watchdog is enabled. It decrements either on every clock or, with prescaling on, once per 2^PRESCALE_LOG2 clocks. Software keeps it alive by writing two key values to a service register, in a fixed order. A successful service reloads the counter from the programmed time count. If the counter reaches zero, the block raises one of two outputs, chosen by a select bit: a reset request or an interrupt.

Configuration is write-once. After power-on reset, the first write to the control register is accepted and moves the configuration state machine from `CFG_OPEN` to `CFG_LOCKED`. Every later control write is ignored, so a running watchdog cannot be stopped and a stopped one cannot be started.

The key checker is a second state machine with two states. In `KEY_IDLE`, the first key moves it to `KEY_ARMED`, and any other value keeps it in `KEY_IDLE`. In `KEY_ARMED`, a repeat of the first key keeps it in `KEY_ARMED`. The second key returns it to `KEY_IDLE` and fires the service. Any other value returns it to `KEY_IDLE` without a service.

The parameter POR_ENABLED sets whether the block leaves reset already counting. PRESCALE_LOG2 selects the prescale ratio: 16 by default, or 11 for the alternate ratio of 2048.

Top module: `svc_watchdog`

## Requirements
- R1: After reset, the control register reads 0xFFFF0003 when POR_ENABLED is 0, and the count register reads 0xFFFF.
- R2: The register offsets are as follows: control at byte 0x04, count at 0x08 (read-only), service at 0x0E (write-only, reads zero). Offsets 0x00, 0x0C and all other offsets read zero, and writes to them change nothing.
- R3: The control fields are: time count in bits 31:16, enable in bit 2, reset select in bit 1 and prescale enable in bit 0. The first control write loads the counter with the written time count, and a written time count of 0 is stored as 1.
- R4: After the first control write, later control writes change no field and do not reload the counter, whether they try to disable or to enable.
- R5: While enabled, the counter decrements once per clock when bit 0 is 0, and once per 2^PRESCALE_LOG2 clocks when bit 0 is 1. While disabled, the counter holds.
- R6: Writing 0x556C and then 0xAA39 to the service register reloads the counter from the time count, on the clock edge of the 0xAA39 write. Repeats of 0x556C before 0xAA39 are allowed.
- R7: A service write of any other value, or 0xAA39 that is not preceded by 0x556C, returns the key checker to idle and does not reload the counter.
- R8: The counter stops at zero. The expiry state is set one clock after the counter reaches zero.
- R9: When reset select is 1, expiry drives `rst_req`, which stays high through any service until reset.
- R10: When reset select is 0, expiry drives `irq`. A valid service clears `irq` and reloads the counter on the same edge.
- R11: With POR_ENABLED set to 1, the control register reads 0xFFFF0007 after reset and the counter runs with no write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low power-on reset |
| wr_en | input | 1 | Write strobe for one cycle |
| addr | input | ADDR_W | Byte offset of the access |
| wdata | input | 32 | Write data; service writes use bits 15:0 |
| rdata | output | 32 | Read data for `addr`, combinational |
| rst_req | output | 1 | Expiry in reset mode, held until reset |
| irq | output | 1 | Expiry in interrupt mode, cleared by service |

## Verification
A key checker stuck in `KEY_ARMED` would let a lone 0xAA39 reload the counter. This shows up on the count register on the very next read. A configuration machine that fails to reach `CFG_LOCKED` shows up as a changed control readback one cycle after the second write. A prescaler or counter fault shifts the zero crossing, and the bench samples the expiry outputs on the exact cycle before and after it. A lost sticky state shows as `rst_req` falling after a service.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int CNT_W = 16;
    localparam logic [CNT_W-1:0] KEY_FIRST  = 16'h556C;
    localparam logic [CNT_W-1:0] KEY_SECOND = 16'hAA39;
    localparam logic [7:0] OFS_CTRL  = 8'h04;
    localparam logic [7:0] OFS_COUNT = 8'h08;
    localparam logic [7:0] OFS_SVC   = 8'h0E;

    typedef enum logic {KEY_IDLE, KEY_ARMED} key_state_e;
    typedef enum logic {CFG_OPEN, CFG_LOCKED} cfg_state_e;

    typedef struct packed {
        logic [CNT_W-1:0] tc;
        logic             en;
        logic             sel;
        logic             pre;
    } ctrl_t;
endpackage

// File: rtl/wdt_key_fsm.sv
module wdt_key_fsm
    import wdt_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr,
    input  logic [CNT_W-1:0] data,
    output logic             svc_ok
);
    key_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= KEY_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (wr) begin
            unique case (state_q)
                KEY_IDLE:  state_d = (data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                KEY_ARMED: state_d = (data == KEY_FIRST) ? KEY_ARMED : KEY_IDLE;
                default:   state_d = KEY_IDLE;
            endcase
        end
    end

    always_comb begin
        svc_ok = wr && (state_q == KEY_ARMED) && (data == KEY_SECOND);
    end

    // R7
    key_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && data != KEY_FIRST) |=> (state_q == KEY_IDLE));
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int LOG2 = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic bypass,
    input  logic restart,
    output logic tick
);
    logic [LOG2-1:0] pcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                          pcnt_q <= '0;
        else if (restart || !run || bypass)  pcnt_q <= '0;
        else                                 pcnt_q <= pcnt_q + 1'b1;
    end

    assign tick = run && (bypass || (&pcnt_q));

    // R5
    tick_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !bypass && !restart && tick) |=> !tick);
endmodule

// File: rtl/wdt_countdown.sv
module wdt_countdown #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    input  logic         svc,
    input  logic         hold_flag,
    output logic [W-1:0] count,
    output logic         expired
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    count <= '1;
        else if (load)                 count <= load_val;
        else if (tick && count != '0)  count <= count - W'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 expired <= 1'b0;
        else if (svc && !hold_flag) expired <= 1'b0;
        else if (count == '0)       expired <= 1'b1;
    end

    // R8
    zero_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count == '0 && !load) |=> (count == '0));
endmodule

// File: rtl/svc_watchdog.sv
module svc_watchdog
    import wdt_pkg::*;
#(
    parameter int PRESCALE_LOG2 = 16,
    parameter bit POR_ENABLED   = 1'b0,
    parameter int ADDR_W        = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output logic [31:0]       rdata,
    output logic              rst_req,
    output logic              irq
);
    localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_COUNT = ADDR_W'(OFS_COUNT);
    localparam logic [ADDR_W-1:0] A_SVC   = ADDR_W'(OFS_SVC);

    cfg_state_e       cfg_q, cfg_d;
    ctrl_t            ctrl_q;
    logic             ctrl_wr, svc_wr, accept, svc_ok, load, tick, expired;
    logic [CNT_W-1:0] tc_new, load_val, count;

    assign ctrl_wr = wr_en && (addr == A_CTRL);
    assign svc_wr  = wr_en && (addr == A_SVC);
    assign accept  = ctrl_wr && (cfg_q == CFG_OPEN);
    assign tc_new  = (wdata[31:16] == '0) ? CNT_W'(1) : wdata[31:16];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_OPEN;
        else        cfg_q <= cfg_d;
    end

    always_comb begin
        cfg_d = cfg_q;
        unique case (cfg_q)
            CFG_OPEN:   if (accept) cfg_d = CFG_LOCKED;
            CFG_LOCKED: cfg_d = CFG_LOCKED;
            default:    cfg_d = CFG_OPEN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '{tc: '1, en: POR_ENABLED, sel: 1'b1, pre: 1'b1};
        end else if (accept) begin
            ctrl_q <= '{tc: tc_new, en: wdata[2], sel: wdata[1], pre: wdata[0]};
        end
    end

    assign load     = accept || svc_ok;
    assign load_val = accept ? tc_new : ctrl_q.tc;

    wdt_key_fsm u_key (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (svc_wr),
        .data   (wdata[CNT_W-1:0]),
        .svc_ok (svc_ok)
    );

    wdt_prescaler #(.LOG2(PRESCALE_LOG2)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (ctrl_q.en),
        .bypass  (!ctrl_q.pre),
        .restart (load),
        .tick    (tick)
    );

    wdt_countdown #(.W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_val  (load_val),
        .tick      (tick),
        .svc       (svc_ok),
        .hold_flag (ctrl_q.sel),
        .count     (count),
        .expired   (expired)
    );

    always_comb begin
        rdata   = '0;
        rst_req = expired && ctrl_q.sel;
        irq     = expired && !ctrl_q.sel;
        if (addr == A_CTRL)       rdata = {ctrl_q.tc, 13'b0, ctrl_q.en, ctrl_q.sel, ctrl_q.pre};
        else if (addr == A_COUNT) rdata = {{(32-CNT_W){1'b0}}, count};
    end

    // R4
    lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == CFG_LOCKED) |=> $stable(ctrl_q));

    // R3
    first_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (count == $past(tc_new)));

    // R9
    sticky_rst_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_q == CFG_LOCKED && rst_req) |=> rst_req);
endmodule

// File: tb/svc_watchdog_test.sv
module svc_watchdog_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = 8'h00;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, pe_rdata;
    logic        rst_req, irq, pe_rst_req, pe_irq;
    logic [7:0]  pe_addr = 8'h04;
    int          n_run = 0;
    int          n_fail = 0;
    logic [31:0] val, c0;

    always #10 clk = ~clk;

    svc_watchdog #(.PRESCALE_LOG2(3), .POR_ENABLED(1'b0), .ADDR_W(8)) uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rst_req(rst_req), .irq(irq));

    svc_watchdog #(.PRESCALE_LOG2(3), .POR_ENABLED(1'b1), .ADDR_W(8)) uut_pe (
        .clk(clk), .rst_n(rst_n), .wr_en(1'b0), .addr(pe_addr), .wdata(32'h0),
        .rdata(pe_rdata), .rst_req(pe_rst_req), .irq(pe_irq));

    localparam int NV = 6;
    localparam logic [7:0]  RD_ADDR [NV] = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h0E, 8'h10};
    localparam logic [31:0] RD_EXP  [NV] = '{32'h0, 32'hFFFF0003, 32'h0000FFFF, 32'h0, 32'h0, 32'h0};

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] v);
        addr = a;
        #1;
        v = rdata;
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        do_reset();
        // R11: power-on enabled variant
        pe_addr = 8'h04; #1;
        chk("R11 pe ctrl", pe_rdata, 32'hFFFF0007);
        pe_addr = 8'h08;
        repeat (20) @(negedge clk);
        #1;
        chk("R11 pe count runs", pe_rdata, 32'h0000FFFD);

        // R1 R2: reset readback table
        for (int i = 0; i < NV; i++) begin
            rd(RD_ADDR[i], val);
            chk("R1/R2 reset read", val, RD_EXP[i]);
        end
        // R2: writes to reserved and count offsets ignored
        wr(8'h00, 32'h12345678);
        wr(8'h08, 32'h00000005);
        wr(8'h0C, 32'hFFFFFFFF);
        rd(8'h00, val); chk("R2 reserved read", val, 32'h0);
        rd(8'h08, val); chk("R2 count read-only", val, 32'h0000FFFF);
        rd(8'h04, val); chk("R2 ctrl untouched", val, 32'hFFFF0003);

        // R3: first control write, interrupt mode, no prescale
        wr(8'h04, 32'h00280004);
        rd(8'h08, val); chk("R3 first load", val, 32'd40);
        rd(8'h04, val); chk("R3 ctrl fields", val, 32'h00280004);
        repeat (5) @(negedge clk);
        rd(8'h08, val); chk("R5 per-clock decrement", val, 32'd35);

        // R4: disable attempt ignored
        wr(8'h04, 32'h00100003);
        rd(8'h04, val); chk("R4 ctrl locked", val, 32'h00280004);
        rd(8'h08, val); chk("R4 no reload", val, 32'd34);

        // R6: valid sequence
        wr(8'h0E, 32'h0000556C);
        wr(8'h0E, 32'h0000AA39);
        rd(8'h08, val); chk("R6 reload", val, 32'd40);
        repeat (3) @(negedge clk);
        wr(8'h0E, 32'h0000556C);
        wr(8'h0E, 32'h0000556C);
        wr(8'h0E, 32'h0000AA39);
        rd(8'h08, val); chk("R6 repeated first key", val, 32'd40);

        // R7: broken sequences
        wr(8'h0E, 32'h0000AA39);
        rd(8'h08, val); chk("R7 lone second key", val, 32'd39);
        wr(8'h0E, 32'h0000556C);
        wr(8'h0E, 32'h00001234);
        wr(8'h0E, 32'h0000AA39);
        rd(8'h08, val); chk("R7 wrong value between", val, 32'd36);

        // R8 R10: expiry in interrupt mode
        repeat (36) @(negedge clk);
        rd(8'h08, val); chk("R8 count at zero", val, 32'd0);
        chk("R8 no expiry yet", {31'b0, irq}, 32'd0);
        @(negedge clk);
        chk("R10 irq raised", {31'b0, irq}, 32'd1);
        chk("R10 no reset request", {31'b0, rst_req}, 32'd0);
        repeat (5) @(negedge clk);
        rd(8'h08, val); chk("R8 stops at zero", val, 32'd0);
        wr(8'h0E, 32'h0000556C);
        wr(8'h0E, 32'h0000AA39);
        chk("R10 irq cleared", {31'b0, irq}, 32'd0);
        rd(8'h08, val); chk("R10 reload on clear", val, 32'd40);

        // R5 R9: prescaled reset mode
        do_reset();
        wr(8'h04, 32'h000A0007);
        rd(8'h08, val); chk("R3 load prescaled", val, 32'd10);
        repeat (7) @(negedge clk);
        rd(8'h08, val); chk("R5 prescale hold", val, 32'd10);
        @(negedge clk);
        rd(8'h08, val); chk("R5 prescale step", val, 32'd9);
        repeat (72) @(negedge clk);
        rd(8'h08, val); chk("R8 zero prescaled", val, 32'd0);
        chk("R9 not yet", {31'b0, rst_req}, 32'd0);
        @(negedge clk);
        chk("R9 rst_req raised", {31'b0, rst_req}, 32'd1);
        chk("R9 no irq", {31'b0, irq}, 32'd0);
        wr(8'h0E, 32'h0000556C);
        wr(8'h0E, 32'h0000AA39);
        chk("R9 sticky after service", {31'b0, rst_req}, 32'd1);
        rd(8'h08, val); chk("R9 counter reloaded", val, 32'd10);

        // R3 R4 R5: zero time count, disabled, enable attempt ignored
        do_reset();
        wr(8'h04, 32'h00000000);
        rd(8'h04, val); chk("R3 zero count stored as one", val, 32'h00010000);
        rd(8'h08, val); c0 = val;
        repeat (4) @(negedge clk);
        rd(8'h08, val); chk("R5 disabled holds", val, c0);
        wr(8'h04, 32'h00050004);
        rd(8'h04, val); chk("R4 enable attempt ignored", val, 32'h00010000);
        rd(8'h08, val); chk("R4 count unchanged", val, 32'd1);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule